// File: doc/BRIEF.md
# Protection Unit Configuration Register Bank

This block keeps the programmable state of a memory protection unit. It holds a global control word and a set of region descriptors, one per protection region. Each descriptor has a base address and an attribute/size word. Software reaches the bank over a simple synchronous bus made of a byte offset, a write strobe, write data and combinational read data. The stored values go out on flat vectors to the access checker, which is a separate block. This block does not check accesses or raise faults.

Software normally chooses a region through an index register and then writes that region's base and attribute words. A base write can also carry its own region index, so one write both selects the region and stores its base. Three extra pairs of offsets mirror the base/attribute pair, so a table of descriptors can be written in a burst of consecutive stores. Fields that are reserved are not stored and always read as zero.

Top module: `prot_cfg_bank`

## Requirements
- R1: Offset 0x90 reads 0x00000800 (region count 8 in bits [15:8], all other bits 0), and writes to it have no effect.
- R2: After synchronous reset the control word, the region index and every descriptor are 0, so all control outputs and descriptor outputs are 0.
- R3: Control word at 0x94: bit 0 drives `prot_enable`, bit 1 drives `fault_bypass`, bit 2 drives `bg_map_enable`. Its other bits are not stored and read as 0.
- R4: The region index at 0x98 stores write data bits [7:0] and reads back in bits [7:0]. Base and attribute accesses go to the region that the index selects.
- R5: While the index is 8 or more, base and attribute writes that carry no in-range override are discarded. Attribute reads return 0, and base reads return 0 in bits [31:4].
- R6: A base write (0x9C) with bit 4 = 1 and bits [3:0] below 8 stores the base into region bits [3:0] and also sets the region index to that value.
- R7: A base write with bit 4 = 1 and bits [3:0] of 8 or more ignores the override. The write goes to the region already selected, and the index is left unchanged.
- R8: A base read returns the stored base in bits [31:5], 0 in bit 4 and index bits [3:0] in bits [3:0]. Write data bits [4:0] are never stored as base.
- R9: The attribute word at 0xA0 keeps only bits under mask 0x173FFF3F: execute-never 28, permission [26:24], type extension [21:19], shareable 18, cacheable 17, bufferable 16, subregion disable [15:8], size [5:1], enable 0. Writing 0x0307002F reads back 0x0307002F.
- R10: Offsets 0xA4, 0xAC and 0xB4 act exactly like the base register, and 0xA8, 0xB0 and 0xB8 act exactly like the attribute register.
- R11: Any other offset reads 0, and writes to it have no effect.
- R12: The descriptor outputs (`region_base_flat`, `region_attr_flat`, region i at bits [32i+31:32i]) show the stored value from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| prot_enable | output | 1 | Global unit enable |
| fault_bypass | output | 1 | Protection bypass in fault handlers |
| bg_map_enable | output | 1 | Background map for privileged accesses |
| region_base_flat | output | 256 | Base words of all regions |
| region_attr_flat | output | 256 | Attribute words of all regions |

## Verification
The bench goes after the override shortcut from both sides. With an in-range override, a design that ignored the override would write the region already selected and leave the index unchanged. With an out-of-range override, a design that honoured it would change the index or lose the base. It also moves the index out of range: a design without that guard would wrap the index and overwrite a real region, which the bench sees when it reads that region back. Reserved-bit masking, the alias offsets and the bit layout of the base read are checked, because each fails visibly: a stray bit reads back, a write lands nowhere, or the index bits are missing from the base read.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;
    parameter int NREG        = 8;
    parameter int IDX_W       = $clog2(NREG);
    parameter int ADDR_W      = 8;
    parameter int DATA_W      = 32;
    parameter int BASE_LSB    = 5;

    localparam logic [ADDR_W-1:0] OFS_TYPE  = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h94;
    localparam logic [ADDR_W-1:0] OFS_NUM   = 8'h98;
    localparam logic [ADDR_W-1:0] OFS_PAIR0 = 8'h9C;
    localparam int                NUM_PAIRS = 4;

    localparam logic [DATA_W-1:0] ATTR_MASK = 32'h173F_FF3F;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_0007;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TYPE,
        SEL_CTRL,
        SEL_NUM,
        SEL_BASE,
        SEL_ATTR
    } reg_sel_e;

    typedef struct packed {
        logic bg_map;
        logic bypass;
        logic enable;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] keep_base(input logic [DATA_W-1:0] d);
        return {d[DATA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/prot_addr_decode.sv
module prot_addr_decode
    import prot_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int PAIR_SPAN = NUM_PAIRS * 8;

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel = addr - OFS_PAIR0;
        sel = SEL_NONE;
        if (addr == OFS_TYPE)      sel = SEL_TYPE;
        else if (addr == OFS_CTRL) sel = SEL_CTRL;
        else if (addr == OFS_NUM)  sel = SEL_NUM;
        else if (addr >= OFS_PAIR0 && int'(rel) < PAIR_SPAN && rel[1:0] == 2'b00)
            sel = rel[2] ? SEL_ATTR : SEL_BASE;
    end
endmodule

// File: rtl/prot_region_slot.sv
module prot_region_slot
    import prot_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_base,
    input  logic              wr_attr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] attr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            attr_q <= '0;
        end else begin
            if (wr_base) base_q <= keep_base(wdata);
            if (wr_attr) attr_q <= wdata & ATTR_MASK;
        end
    end

    // R9: reserved attribute positions never hold a one
    p_attr_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        (attr_q & ~ATTR_MASK) == '0);

    // R8: low base bits are never stored
    p_base_low_r8: assert property (@(posedge clk) disable iff (rst)
        base_q[BASE_LSB-1:0] == '0);

    // R12: an idle slot keeps its contents
    p_slot_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !wr_base && !wr_attr |=> $stable(base_q) && $stable(attr_q));
endmodule

// File: rtl/prot_cfg_bank.sv
module prot_cfg_bank
    import prot_cfg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   prot_enable,
    output logic                   fault_bypass,
    output logic                   bg_map_enable,
    output logic [NREG*DATA_W-1:0] region_base_flat,
    output logic [NREG*DATA_W-1:0] region_attr_flat
);
    reg_sel_e          sel;
    ctrl_t             ctrl_q;
    logic [7:0]        region_num_q;
    logic [7:0]        ovr_idx;
    logic              ovr_ok;
    logic [7:0]        base_target;
    logic              num_ok;
    logic              base_target_ok;
    logic [NREG-1:0]   wr_base_vec;
    logic [NREG-1:0]   wr_attr_vec;
    logic [DATA_W-1:0] base_arr [NREG];
    logic [DATA_W-1:0] attr_arr [NREG];

    prot_addr_decode u_dec (.addr(bus_addr), .sel(sel));

    always_comb begin
        ovr_idx        = {4'b0, bus_wdata[3:0]};
        ovr_ok         = (sel == SEL_BASE) && bus_wdata[4] && (ovr_idx < 8'(NREG));
        base_target    = ovr_ok ? ovr_idx : region_num_q;
        base_target_ok = base_target < 8'(NREG);
        num_ok         = region_num_q < 8'(NREG);
    end

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_slot
            assign wr_base_vec[i] = bus_wr && (sel == SEL_BASE) && base_target_ok
                                    && (base_target == 8'(i));
            assign wr_attr_vec[i] = bus_wr && (sel == SEL_ATTR) && num_ok
                                    && (region_num_q == 8'(i));
            prot_region_slot u_slot (
                .clk    (clk),
                .rst    (rst),
                .wr_base(wr_base_vec[i]),
                .wr_attr(wr_attr_vec[i]),
                .wdata  (bus_wdata),
                .base_q (base_arr[i]),
                .attr_q (attr_arr[i])
            );
            assign region_base_flat[i*DATA_W +: DATA_W] = base_arr[i];
            assign region_attr_flat[i*DATA_W +: DATA_W] = attr_arr[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            region_num_q <= '0;
        end else if (bus_wr) begin
            if (sel == SEL_CTRL) ctrl_q <= bus_wdata[2:0];
            if (sel == SEL_NUM)  region_num_q <= bus_wdata[7:0];
            else if (ovr_ok)     region_num_q <= ovr_idx;
        end
    end

    assign prot_enable   = ctrl_q.enable;
    assign fault_bypass  = ctrl_q.bypass;
    assign bg_map_enable = ctrl_q.bg_map;

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_TYPE: bus_rdata = {16'b0, 8'(NREG), 8'b0};
            SEL_CTRL: bus_rdata = {29'b0, ctrl_q};
            SEL_NUM:  bus_rdata = {24'b0, region_num_q};
            SEL_BASE: bus_rdata = {num_ok ? base_arr[region_num_q[IDX_W-1:0]][DATA_W-1:BASE_LSB]
                                          : {(DATA_W-BASE_LSB){1'b0}},
                                   1'b0, region_num_q[3:0]};
            SEL_ATTR: bus_rdata = num_ok ? attr_arr[region_num_q[IDX_W-1:0]] : '0;
            default:  bus_rdata = '0;
        endcase
    end

    // R2: control word is clear in the first cycle after reset
    p_ctrl_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == '0) && (region_num_q == '0));

    // R6: in-range override moves the index
    p_override_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_BASE && bus_wdata[4] && bus_wdata[3:0] < 4'(NREG))
        |=> region_num_q == $past({4'b0, bus_wdata[3:0]}));

    // R7: out-of-range override leaves the index alone
    p_override_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_BASE && bus_wdata[4] && bus_wdata[3:0] >= 4'(NREG))
        |=> $stable(region_num_q));

    // R4: at most one region takes a base or attribute write
    p_one_target_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_base_vec) && $onehot0(wr_attr_vec));

    // R5: an out-of-range index blocks attribute writes
    p_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        !num_ok |-> wr_attr_vec == '0);
endmodule

// File: tb/prot_cfg_bank_tb_top.sv
module prot_cfg_bank_tb_top;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        prot_enable, fault_bypass, bg_map_enable;
    logic [NR*32-1:0] region_base_flat, region_attr_flat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_base [NR];
    logic [31:0] m_attr [NR];
    logic [2:0]  m_ctrl;
    logic [7:0]  m_num;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [7:0]  adr_q [$];

    always #4 clk = ~clk;

    prot_cfg_bank dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prot_enable(prot_enable), .fault_bypass(fault_bypass),
        .bg_map_enable(bg_map_enable),
        .region_base_flat(region_base_flat), .region_attr_flat(region_attr_flat)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic bit is_base(input logic [7:0] a);
        return a == 8'h9C || a == 8'hA4 || a == 8'hAC || a == 8'hB4;
    endfunction
    function automatic bit is_attr(input logic [7:0] a);
        return a == 8'hA0 || a == 8'hA8 || a == 8'hB0 || a == 8'hB8;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a == 8'h90) return 32'h0000_0800;
        if (a == 8'h94) return {29'b0, m_ctrl};
        if (a == 8'h98) return {24'b0, m_num};
        if (is_base(a)) return {(m_num < 8) ? m_base[m_num[2:0]][31:5] : 27'b0, 1'b0, m_num[3:0]};
        if (is_attr(a)) return (m_num < 8) ? m_attr[m_num[2:0]] : 32'b0;
        return 32'b0;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [7:0] t;
        @(posedge clk); #1;
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        if (a == 8'h94) m_ctrl = d[2:0];
        else if (a == 8'h98) m_num = d[7:0];
        else if (is_base(a)) begin
            if (d[4] && d[3:0] < 8) begin t = {4'b0, d[3:0]}; m_num = t; end
            else t = m_num;
            if (t < 8) m_base[t[2:0]] = {d[31:5], 5'b0};
        end else if (is_attr(a)) begin
            if (m_num < 8) m_attr[m_num[2:0]] = d & 32'h173F_FF3F;
        end
    endtask

    // driver: pushes the expected read value, monitor compares it
    task automatic rd(input logic [7:0] a, input string tag);
        @(posedge clk); #1;
        bus_addr = a; bus_wr = 1'b0;
        exp_q.push_back(exp_rd(a));
        tag_q.push_back(tag);
        adr_q.push_back(a);
        @(posedge clk);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            logic [7:0]  a;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = adr_q.pop_front();
            check($sformatf("%s @%02h", t, a), bus_rdata, e);
        end
    end

    task automatic check_outputs(input string tag);
        @(negedge clk);
        check({tag, " ctrl"}, {29'b0, bg_map_enable, fault_bypass, prot_enable}, {29'b0, m_ctrl});
        for (int i = 0; i < NR; i++) begin
            check($sformatf("%s base%0d", tag, i), region_base_flat[i*32 +: 32], m_base[i]);
            check($sformatf("%s attr%0d", tag, i), region_attr_flat[i*32 +: 32], m_attr[i]);
        end
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin m_base[i] = '0; m_attr[i] = '0; end
        m_ctrl = '0; m_num = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2 reset state
        check_outputs("R2");
        rd(8'h94, "R2");
        rd(8'h98, "R2");
        // R1 type register, read-only
        rd(8'h90, "R1");
        wr(8'h90, 32'hFFFF_FFFF);
        rd(8'h90, "R1");
        // R3 control bits
        wr(8'h94, 32'hFFFF_FFFF);
        rd(8'h94, "R3");
        check_outputs("R3");
        wr(8'h94, 32'h0000_0005);
        check_outputs("R3");
        rd(8'h94, "R3");
        // R4 / R9 / R12 select region 2, program it
        wr(8'h98, 32'h0000_0002);
        rd(8'h98, "R4");
        wr(8'hA0, 32'h0307_002F);
        rd(8'hA0, "R9");
        check("R9 size", {27'b0, region_attr_flat[2*32+1 +: 5]}, 32'd23);
        check("R9 perm", {29'b0, region_attr_flat[2*32+24 +: 3]}, 32'd3);
        wr(8'h9C, 32'h2000_001F);
        rd(8'h9C, "R8");
        check_outputs("R12");
        wr(8'hA0, 32'hFFFF_FFFF);
        rd(8'hA0, "R9");
        // R6 in-range override
        wr(8'h9C, 32'h4000_0015);
        rd(8'h98, "R6");
        rd(8'h9C, "R6");
        // R7 out-of-range override
        wr(8'h9C, 32'h6000_001C);
        rd(8'h98, "R7");
        rd(8'h9C, "R7");
        // R4 switching the index shows the other region
        wr(8'h98, 32'h0000_0002);
        rd(8'hA0, "R4");
        rd(8'h9C, "R4");
        // R5 out-of-range index
        wr(8'h98, 32'h0000_0009);
        wr(8'hA0, 32'h0000_0001);
        wr(8'h9C, 32'hF000_0000);
        rd(8'hA0, "R5");
        rd(8'h9C, "R5");
        check_outputs("R5");
        wr(8'h98, 32'h0000_0001);
        rd(8'hA0, "R5");
        rd(8'h9C, "R5");
        // R10 aliases
        wr(8'hAC, 32'h8000_0013);
        rd(8'hA4, "R10");
        rd(8'h98, "R10");
        wr(8'hB8, 32'h0000_0011);
        rd(8'hA0, "R10");
        wr(8'hB4, 32'h9000_0000);
        rd(8'h9C, "R10");
        wr(8'hA8, 32'h1000_0000);
        rd(8'hB0, "R10");
        check_outputs("R10");
        // R11 unmapped offsets
        wr(8'hC0, 32'hFFFF_FFFF);
        wr(8'h9E, 32'hFFFF_FFFF);
        rd(8'hC0, "R11");
        rd(8'h9E, "R11");
        rd(8'h80, "R11");
        check_outputs("R11");

        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule